// File: doc/BRIEF.md
# One-Bit Third-Order Comb Decimator

This block turns a one-bit oversampled stream, such as the output of a sigma-delta modulator, into a stream of signed multi-bit words. It applies a third-order sinc (comb) response and decimates by `M = 2**LOG2M`, producing one word for every `M` accepted input bits. The response spans three consecutive frames of `M` bits. Three rotating partial-sum accumulators cover those frames, and each one is at a different age within its window.

Each input bit is used in the cycle it is accepted and then dropped. No delay line holds past bits. A phase counter and a rotation counter pick the tap value each accumulator needs for the current bit. Because the input is one bit wide, the bit only decides whether that tap is added or subtracted, so no multipliers are needed.

Both stream edges use valid/ready. The input accepts a bit when `in_valid` and `in_ready` are both high at a clock edge. A result stays on `out_data` with `out_valid` high until `out_ready` takes it. While a result is waiting and `out_ready` is low, `in_ready` is low. This back-pressure stops the input, so no bit is lost and no result is overwritten.

Top module: `sinc3_decim`

## Requirements
- R1: The synchronous reset `rst` clears the phase, the rotation, the fill count and all three accumulators. It also drops `out_valid` and raises `in_ready`. A reset in the middle of a frame leaves no trace in later results.
- R2: An accepted bit counts as +1 when it is 1 and as -1 when it is 0. Take the 3M accepted bits of a window, numbered j = 0 (the oldest) up to 3M-1. The window's result is the sum of h[j]·x[j], where h[j] is the number of triples (a,b,c), each in 0..M-1, with a+b+c = j. This makes h zero for j ≥ 3M-2.
- R3: A result is emitted after the last bit of each frame of M accepted bits, starting with the third frame. The first two frame ends after reset emit nothing. Consecutive windows are spaced M bits apart.
- R4: A constant stream of ones gives a steady +M³, and a constant stream of zeros gives a steady -M³.
- R5: The last two bits of a window (j = 3M-2 and j = 3M-1) have no effect on that window's result.
- R6: In a cycle where no transfer happens (`in_valid` low), the phase, rotation and accumulators hold, and `in_bit` has no effect.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` is held stable and `in_ready` is low, so no bit is accepted.
- R8: `out_data` is a signed two's-complement word of 3·LOG2M+2 bits. Its value, and every accumulator, stays within ±M³.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Block can take the offered bit |
| in_bit | input | 1 | Oversampled data bit (1 = +1, 0 = -1) |
| out_valid | output | 1 | A result is present on out_data |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 3·LOG2M+2 | Signed decimated result |

## Verification
At a frame's closing bit, two things happen in the same cycle: the oldest accumulator adds that bit to finish its sum for output, and it restarts at zero for a new frame while the other two accumulators also take the bit. The bench provokes this with single-one patterns, with patterns whose last bit differs from the rest, and with a pseudo-random stream. It checks each result against a window model computed from the tap definition, so a closing bit that is dropped, counted twice or kept in the restarted sum shows up as a wrong value. A second coincidence is the hand-off of a held result in the same edge that accepts a bit which was stalled. The bench holds `out_ready` low with a bit offered, and then checks that exactly one result is collected and that the next window counts the stalled bit once.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int NSLOT = 3;

  typedef logic [1:0] slot_t;

  // Tap value of the triple boxcar convolution at index n for frame length m.
  function automatic int unsigned sinc3_tap(input int unsigned n, input int unsigned m);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned a = 0; a < m; a++) begin
      for (int unsigned b = 0; b < m; b++) begin
        if ((n >= a + b) && (n - a - b < m)) cnt++;
      end
    end
    return cnt;
  endfunction

  // Age (frames already spent in the window) of accumulator slot i.
  function automatic slot_t slot_age(input int i, input slot_t rot);
    int s;
    s = i + int'(rot);
    if (s >= NSLOT) s = s - NSLOT;
    return slot_t'(s);
  endfunction

  // Slot whose window closes at the current frame end.
  function automatic slot_t oldest_slot(input slot_t rot);
    case (rot)
      2'd0:    return 2'd2;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sinc3_phase_ctrl.sv
module sinc3_phase_ctrl #(
  parameter int LOG2M = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  output logic [LOG2M-1:0]       phase,
  output sinc3_pkg::slot_t       rot,
  output logic                   frame_end,
  output logic                   primed
);
  logic [1:0] fill;

  assign frame_end = step && (phase == '1);
  assign primed    = (fill == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      rot   <= '0;
      fill  <= '0;
    end else if (step) begin
      phase <= phase + 1'b1;
      if (frame_end) begin
        rot <= (rot == 2'd2) ? 2'd0 : rot + 2'd1;
        if (fill != 2'd2) fill <= fill + 2'd1;
      end
    end
  end

  // R6: no transfer, no movement of phase or rotation
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(phase) && $stable(rot)));

  // R3: rotation walks only over the three slots
  p_rot_legal_r3: assert property (@(posedge clk) disable iff (rst)
    rot != 2'd3);

endmodule

// File: rtl/sinc3_coef_rom.sv
module sinc3_coef_rom #(
  parameter int LOG2M = 3,
  parameter int CW    = 2 * LOG2M + 1
) (
  input  logic [LOG2M-1:0]           phase,
  input  sinc3_pkg::slot_t           rot,
  output logic [2:0][CW-1:0]         coef
);
  localparam int M = 1 << LOG2M;

  logic [CW-1:0] tab [sinc3_pkg::NSLOT*M];

  for (genvar g = 0; g < sinc3_pkg::NSLOT; g++) begin : g_age
    for (genvar p = 0; p < M; p++) begin : g_ph
      localparam int unsigned TAP = sinc3_pkg::sinc3_tap(g * M + p, M);
      assign tab[g*M+p] = CW'(TAP);
    end
  end

  for (genvar i = 0; i < sinc3_pkg::NSLOT; i++) begin : g_sel
    sinc3_pkg::slot_t age;
    assign age     = sinc3_pkg::slot_age(i, rot);
    assign coef[i] = tab[int'(age) * M + int'(phase)];
  end

endmodule

// File: rtl/sinc3_acc_bank.sv
module sinc3_acc_bank #(
  parameter int LOG2M = 3,
  parameter int CW    = 2 * LOG2M + 1,
  parameter int AW    = 3 * LOG2M + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     bit_in,
  input  logic                     frame_end,
  input  sinc3_pkg::slot_t         rot,
  input  logic [2:0][CW-1:0]       coef,
  output logic signed [AW-1:0]     close_sum
);
  localparam int M  = 1 << LOG2M;
  localparam int M3 = M * M * M;

  sinc3_pkg::slot_t oldest;
  logic signed [AW-1:0] acc [sinc3_pkg::NSLOT];
  logic signed [AW-1:0] nxt [sinc3_pkg::NSLOT];

  assign oldest = sinc3_pkg::oldest_slot(rot);

  for (genvar i = 0; i < sinc3_pkg::NSLOT; i++) begin : g_acc
    logic signed [AW-1:0] mag;
    assign mag    = $signed(AW'(coef[i]));
    assign nxt[i] = bit_in ? (acc[i] + mag) : (acc[i] - mag);

    always_ff @(posedge clk) begin
      if (rst)
        acc[i] <= '0;
      else if (step)
        acc[i] <= (frame_end && (oldest == 2'(i))) ? '0 : nxt[i];
    end

    // R8: partial sums never leave the full-scale range
    p_acc_bound_r8: assert property (@(posedge clk) disable iff (rst)
      (acc[i] <= M3) && (acc[i] >= -M3));
  end

  assign close_sum = nxt[oldest];

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int LOG2M = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_bit,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic signed [3*LOG2M+1:0]    out_data
);
  localparam int M  = 1 << LOG2M;
  localparam int OW = 3 * LOG2M + 2;
  localparam int CW = 2 * LOG2M + 1;
  localparam int M3 = M * M * M;

  logic                  step;
  logic [LOG2M-1:0]      phase;
  sinc3_pkg::slot_t      rot;
  logic                  frame_end;
  logic                  primed;
  logic [2:0][CW-1:0]    coef;
  logic signed [OW-1:0]  close_sum;

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  sinc3_phase_ctrl #(.LOG2M(LOG2M)) u_ctrl (
    .clk(clk), .rst(rst), .step(step), .phase(phase), .rot(rot),
    .frame_end(frame_end), .primed(primed)
  );

  sinc3_coef_rom #(.LOG2M(LOG2M), .CW(CW)) u_rom (
    .phase(phase), .rot(rot), .coef(coef)
  );

  sinc3_acc_bank #(.LOG2M(LOG2M), .CW(CW), .AW(OW)) u_bank (
    .clk(clk), .rst(rst), .step(step), .bit_in(in_bit),
    .frame_end(frame_end), .rot(rot), .coef(coef), .close_sum(close_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (frame_end && primed) begin
      out_valid <= 1'b1;
      out_data  <= close_sum;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a held result keeps its value
  p_hold_data_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: no bit enters while the result is blocked
  p_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(phase));

  // R3: a new result only follows a frame's closing bit
  p_emit_on_close_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(frame_end));

  // R8: result within full scale
  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data <= M3) && (out_data >= -M3)));

endmodule

// File: tb/sinc3_decim_test.sv
module sinc3_decim_test;
  localparam int CLK   = 10;
  localparam int LOG2M = 3;
  localparam int M     = 1 << LOG2M;
  localparam int OW    = 3 * LOG2M + 2;
  localparam int M3    = M * M * M;
  localparam int NVEC  = 8;

  // three-frame stimulus (bit s sent s-th) and its expected result, M = 8
  localparam logic [23:0] STIM [NVEC] = '{
    24'hFFFFFF, 24'h000000, 24'h000001, 24'h000400,
    24'h800000, 24'h400000, 24'h0000FF, 24'h555555 };
  localparam int EXPV [NVEC] = '{ 512, -512, -510, -416, -512, -512, -272, 0 };

  logic clk, rst, in_valid, in_ready, in_bit, out_valid, out_ready;
  logic signed [OW-1:0] out_data;

  int total, bad, nacc, ngot;
  bit hist [0:255];
  int got  [0:63];
  logic [15:0] lfsr;

  sinc3_decim #(.LOG2M(LOG2M)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      got[ngot] = int'(out_data);
      ngot++;
    end
  end

  function automatic int btap(input int n);
    int c;
    c = 0;
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++)
        for (int d = 0; d < M; d++)
          if (a + b + d == n) c++;
    return c;
  endfunction

  function automatic int model(input int r);
    int y;
    y = 0;
    for (int j = 0; j < 3 * M; j++)
      y += btap(j) * (hist[r*M+j] ? 1 : -1);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    nacc = 0;
    ngot = 0;
  endtask

  task automatic send_bit(input bit b);
    bit ok;
    in_valid = 1'b1;
    in_bit = b;
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #1;
    end while (!ok);
    hist[nacc] = b;
    nacc++;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      in_bit = ~in_bit;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; nacc = 0; ngot = 0;
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b1;
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    // table walk: R2, R3, R5
    for (int k = 0; k < NVEC; k++) begin
      do_reset();
      for (int s = 0; s < 3 * M; s++) begin
        if (s == 2 * M) begin
          settle();
          chk(ngot == 0, "R3 no result for first two frames", ngot, 0);
        end
        send_bit(STIM[k][s]);
      end
      settle();
      chk(ngot == 1, "R3 one result after third frame", ngot, 1);
      chk(got[0] == EXPV[k], (k == 4 || k == 5) ? "R5 tail bits weightless" : "R2 window sum",
          got[0], EXPV[k]);
    end

    // R1: reset mid-frame leaves no trace
    do_reset();
    for (int s = 0; s < 13; s++) send_bit(s[0]);
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after mid-run reset", int'(out_valid), 0);
    @(posedge clk); #1;
    for (int s = 0; s < 3 * M; s++) send_bit(1'b0);
    settle();
    chk(ngot == 1 && got[0] == -M3, "R1 fresh result after reset", got[0], -M3);

    // R4: steady ones
    do_reset();
    for (int s = 0; s < 6 * M; s++) send_bit(1'b1);
    settle();
    chk(ngot == 4, "R4 result count", ngot, 4);
    for (int r = 0; r < 4; r++)
      chk(got[r] == M3, "R4 steady +M^3", got[r], M3);

    // R2, R6: pseudo-random stream with idle gaps and toggling in_bit
    do_reset();
    lfsr = 16'hACE1;
    for (int s = 0; s < 8 * M; s++) begin
      send_bit(lfsr[0]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (s % 5 == 2) idle(2);
    end
    settle();
    chk(ngot == 6, "R6 result count with gaps", ngot, 6);
    for (int r = 0; r < 6; r++)
      chk(got[r] == model(r), "R2 R6 random window", got[r], model(r));

    // R7: back-pressure
    do_reset();
    out_ready = 1'b0;
    for (int s = 0; s < 3 * M; s++) send_bit(1'b1);
    fork
      send_bit(1'b0);
      begin
        repeat (4) begin
          @(negedge clk);
          chk(in_ready == 1'b0, "R7 in_ready low while blocked", int'(in_ready), 0);
          chk(out_valid == 1'b1 && out_data == M3, "R7 held result", int'(out_data), M3);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
      end
    join
    for (int s = 0; s < M - 1; s++) send_bit(1'b1);
    settle();
    chk(ngot == 2, "R7 single hand-off per result", ngot, 2);
    chk(got[0] == M3, "R7 first result", got[0], M3);
    chk(got[1] == model(1), "R7 stalled bit counted once", got[1], model(1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule